// File: doc/BRIEF.md
# State-Enable Access Permission Checker

This block decides whether the current execution context of a processor hart may touch a feature that is gated by layered state-enable words. A machine-level word gates everything below machine mode. Under virtualization, a hypervisor-level word adds a further gate. A supervisor-level word gates user mode. The block reports one of two fault kinds when a gate is closed: an illegal-instruction fault, or a virtual-instruction fault.

A caller presents the privilege, the virtualization flag, the two extension-present flags, the three 64-bit enable words and a one-hot selector for the guarded bit, and pulses the request strobe for one cycle. On the next clock edge the verdict is captured into a register and a one-cycle done pulse is raised alongside it. The verdict then holds until the next request.

Top module: `steAccessCheck`

## Requirements
- R1: When privilege is machine (2'b11), or the state-enable extension is absent, the verdict is allow (2'b00) whatever the enable words hold.
- R2: Otherwise the reserved privilege code 2'b10 yields illegal-instruction (2'b01).
- R3: Otherwise, if the machine-level word ANDed with the selector is zero, the verdict is illegal-instruction. This check takes precedence over every hypervisor and supervisor check.
- R4: Otherwise, with virtualization on, a zero hypervisor-level word AND selector yields virtual-instruction fault (2'b10).
- R5: Otherwise, with virtualization on and privilege user (2'b00), a zero supervisor-level word AND selector yields virtual-instruction fault.
- R6: Otherwise, with privilege user and the supervisor extension present, a zero supervisor-level word AND selector yields illegal-instruction. This applies whether or not virtualization is on.
- R7: When every applicable check passes, the verdict is allow. The code 2'b11 is never produced. Privilege supervisor is 2'b01.
- R8: The verdict register is loaded on the clock edge that samples the request strobe high. Done is high for exactly the following cycle, and is low in any cycle not preceded by a request.
- R9: Input changes without a request leave the verdict unchanged.
- R10: A synchronous active-high reset clears done and sets the verdict to allow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqStrobe | input | 1 | Check request, one cycle |
| privLevel | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine, 10 reserved |
| virtOn | input | 1 | Virtualization active |
| stenPresent | input | 1 | State-enable extension implemented |
| supPresent | input | 1 | Supervisor extension implemented |
| mEnable | input | 64 | Machine-level enable word |
| hEnable | input | 64 | Hypervisor-level enable word |
| sEnable | input | 64 | Supervisor-level enable word |
| bitSelect | input | 64 | One-hot selector of the guarded bit |
| verdict | output | 2 | 00 allow, 01 illegal-instruction, 10 virtual-instruction fault |
| done | output | 1 | One-cycle pulse marking a fresh verdict |

## Verification
Both results, the verdict and the done pulse, are due one clock edge after the request strobe is sampled. The bench drives inputs on the falling edge. Its behavioural model updates its expected verdict and done at the same rising edge as the design. The outputs are compared on every falling edge, half a cycle after the edge that produced them. Because the comparison runs in every cycle, the idle cycles between requests also prove that done stays low and that the verdict holds while inputs change.

// File: rtl/steCheckPkg.sv
package steCheckPkg;

  typedef enum logic [1:0] {
    VERDICT_ALLOW   = 2'b00,
    VERDICT_ILLEGAL = 2'b01,
    VERDICT_VIRTUAL = 2'b10
  } verdict_e;

  localparam logic [1:0] PRIV_USER     = 2'b00;
  localparam logic [1:0] PRIV_SUPER    = 2'b01;
  localparam logic [1:0] PRIV_RESERVED = 2'b10;
  localparam logic [1:0] PRIV_MACHINE  = 2'b11;

  typedef struct packed {
    logic capture;
    logic clearOut;
  } ctlStrobes_t;

endpackage

// File: rtl/steCheckCtrl.sv
module steCheckCtrl
  import steCheckPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqStrobe,
  output ctlStrobes_t strobes,
  output logic        done
);

  logic doneQ;

  always_comb begin
    strobes.capture  = reqStrobe && !rst;
    strobes.clearOut = rst;
  end

  always_ff @(posedge clk) begin
    if (rst) doneQ <= 1'b0;
    else     doneQ <= reqStrobe;
  end

  assign done = doneQ;

endmodule

// File: rtl/steCheckData.sv
module steCheckData
  import steCheckPkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  ctlStrobes_t       strobes,
  input  logic [1:0]        privLevel,
  input  logic              virtOn,
  input  logic              stenPresent,
  input  logic              supPresent,
  input  logic [WORD_W-1:0] mEnable,
  input  logic [WORD_W-1:0] hEnable,
  input  logic [WORD_W-1:0] sEnable,
  input  logic [WORD_W-1:0] bitSelect,
  output logic [1:0]        verdict
);

  localparam int LEVELS = 3;

  logic [LEVELS-1:0] gateOpen;
  logic [WORD_W-1:0] levelWord [LEVELS];
  verdict_e          nextVerdict;
  verdict_e          verdictQ;

  assign levelWord[0] = mEnable;
  assign levelWord[1] = hEnable;
  assign levelWord[2] = sEnable;

  for (genvar g = 0; g < LEVELS; g++) begin : gLevel
    assign gateOpen[g] = |(levelWord[g] & bitSelect);
  end

  logic isUser;
  assign isUser = (privLevel == PRIV_USER);

  always_comb begin
    nextVerdict = VERDICT_ALLOW;
    if (privLevel == PRIV_MACHINE || !stenPresent)
      nextVerdict = VERDICT_ALLOW;
    else if (privLevel == PRIV_RESERVED)
      nextVerdict = VERDICT_ILLEGAL;
    else if (!gateOpen[0])
      nextVerdict = VERDICT_ILLEGAL;
    else if (virtOn && !gateOpen[1])
      nextVerdict = VERDICT_VIRTUAL;
    else if (virtOn && isUser && !gateOpen[2])
      nextVerdict = VERDICT_VIRTUAL;
    else if (isUser && supPresent && !gateOpen[2])
      nextVerdict = VERDICT_ILLEGAL;
  end

  always_ff @(posedge clk) begin
    if (strobes.clearOut)     verdictQ <= VERDICT_ALLOW;
    else if (strobes.capture) verdictQ <= nextVerdict;
  end

  assign verdict = verdictQ;

endmodule

// File: rtl/steAccessCheck.sv
module steAccessCheck
  import steCheckPkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqStrobe,
  input  logic [1:0]        privLevel,
  input  logic              virtOn,
  input  logic              stenPresent,
  input  logic              supPresent,
  input  logic [WORD_W-1:0] mEnable,
  input  logic [WORD_W-1:0] hEnable,
  input  logic [WORD_W-1:0] sEnable,
  input  logic [WORD_W-1:0] bitSelect,
  output logic [1:0]        verdict,
  output logic              done
);

  ctlStrobes_t strobes;

  steCheckCtrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .reqStrobe (reqStrobe),
    .strobes   (strobes),
    .done      (done)
  );

  steCheckData #(.WORD_W(WORD_W)) uData (
    .clk         (clk),
    .strobes     (strobes),
    .privLevel   (privLevel),
    .virtOn      (virtOn),
    .stenPresent (stenPresent),
    .supPresent  (supPresent),
    .mEnable     (mEnable),
    .hEnable     (hEnable),
    .sEnable     (sEnable),
    .bitSelect   (bitSelect),
    .verdict     (verdict)
  );

endmodule

// File: rtl/steAccessCheck_chk.sv
module steAccessCheck_chk #(
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              reqStrobe,
  input logic [1:0]        privLevel,
  input logic              stenPresent,
  input logic [WORD_W-1:0] mEnable,
  input logic [WORD_W-1:0] bitSelect,
  input logic [1:0]        verdict,
  input logic              done
);

  // R8
  done_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    reqStrobe |=> done);

  // R8
  done_only_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    !reqStrobe |=> !done);

  // R7
  no_code_three_chk: assert property (@(posedge clk) disable iff (rst)
    verdict != 2'b11);

  // R1
  machine_allow_chk: assert property (@(posedge clk) disable iff (rst)
    (reqStrobe && (privLevel == 2'b11 || !stenPresent)) |=> verdict == 2'b00);

  // R3
  machine_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (reqStrobe && stenPresent && (privLevel == 2'b00 || privLevel == 2'b01)
     && ((mEnable & bitSelect) == '0)) |=> verdict == 2'b01);

  // R9
  hold_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    !reqStrobe |=> $stable(verdict));

endmodule

bind steAccessCheck steAccessCheck_chk #(.WORD_W(WORD_W)) uChk (
  .clk         (clk),
  .rst         (rst),
  .reqStrobe   (reqStrobe),
  .privLevel   (privLevel),
  .stenPresent (stenPresent),
  .mEnable     (mEnable),
  .bitSelect   (bitSelect),
  .verdict     (verdict),
  .done        (done)
);

// File: tb/tb_steAccessCheck.sv
module tb_steAccessCheck;

  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst;
  logic         reqStrobe;
  logic [1:0]   privLevel;
  logic         virtOn, stenPresent, supPresent;
  logic [W-1:0] mEnable, hEnable, sEnable, bitSelect;
  logic [1:0]   verdict;
  logic         done;

  int checks = 0;
  int errors = 0;
  string curReq = "R10";
  logic [1:0] expVerdict;
  logic       expDone;
  logic       finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  steAccessCheck dut (
    .clk(clk), .rst(rst), .reqStrobe(reqStrobe), .privLevel(privLevel),
    .virtOn(virtOn), .stenPresent(stenPresent), .supPresent(supPresent),
    .mEnable(mEnable), .hEnable(hEnable), .sEnable(sEnable),
    .bitSelect(bitSelect), .verdict(verdict), .done(done)
  );

  function automatic logic [1:0] refVerdict(
    input logic [1:0] p, input logic v, input logic st, input logic sp,
    input logic [W-1:0] m, input logic [W-1:0] h, input logic [W-1:0] s,
    input logic [W-1:0] sel);
    bit mOk = (m & sel) != 0;
    bit hOk = (h & sel) != 0;
    bit sOk = (s & sel) != 0;
    if (p == 2'd3 || !st) return 2'd0;
    if (p == 2'd2) return 2'd1;
    if (!mOk) return 2'd1;
    if (v && !hOk) return 2'd2;
    if (v && p == 2'd0 && !sOk) return 2'd2;
    if (p == 2'd0 && sp && !sOk) return 2'd1;
    return 2'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      expDone    <= 1'b0;
      expVerdict <= 2'd0;
    end else begin
      expDone <= reqStrobe;
      if (reqStrobe)
        expVerdict <= refVerdict(privLevel, virtOn, stenPresent, supPresent,
                                 mEnable, hEnable, sEnable, bitSelect);
    end
  end

  always @(negedge clk) begin
    if (!finished && expDone !== 1'bx) begin
      checks++;
      if (verdict !== expVerdict || done !== expDone) begin
        errors++;
        $display("FAIL %s verdict=%0d done=%0d expected verdict=%0d done=%0d",
                 curReq, verdict, done, expVerdict, expDone);
      end
    end
  end

  task automatic request(input string tag, input logic [1:0] p, input logic v,
                         input logic st, input logic sp, input logic [W-1:0] m,
                         input logic [W-1:0] h, input logic [W-1:0] s,
                         input int idx);
    @(negedge clk);
    curReq = tag;
    privLevel = p; virtOn = v; stenPresent = st; supPresent = sp;
    mEnable = m; hEnable = h; sEnable = s; bitSelect = W'(1) << idx;
    reqStrobe = 1'b1;
    @(negedge clk);
    reqStrobe = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ones = '1;
    rst = 1'b1; reqStrobe = 1'b0; privLevel = 2'd0; virtOn = 1'b0;
    stenPresent = 1'b0; supPresent = 1'b0;
    mEnable = '0; hEnable = '0; sEnable = '0; bitSelect = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (verdict !== 2'd0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R10 verdict=%0d done=%0d expected verdict=0 done=0", verdict, done);
    end
    rst = 1'b0;

    // R1
    request("R1", 2'd3, 1'b1, 1'b1, 1'b1, '0, '0, '0, 5);
    request("R1", 2'd0, 1'b1, 1'b0, 1'b1, '0, '0, '0, 7);
    // R2
    request("R2", 2'd2, 1'b0, 1'b1, 1'b1, ones, ones, ones, 3);
    // R3: machine gate wins over others
    request("R3", 2'd0, 1'b1, 1'b1, 1'b1, ones & ~(W'(1) << 9), '0, '0, 9);
    request("R3", 2'd1, 1'b0, 1'b1, 1'b0, '0, ones, ones, 63);
    // R4
    request("R4", 2'd1, 1'b1, 1'b1, 1'b1, ones, '0, ones, 0);
    request("R4", 2'd0, 1'b1, 1'b1, 1'b1, ones, ones & ~(W'(1) << 40), '0, 40);
    // R5
    request("R5", 2'd0, 1'b1, 1'b1, 1'b0, ones, ones, '0, 12);
    // R6
    request("R6", 2'd0, 1'b0, 1'b1, 1'b1, ones, '0, '0, 33);
    // R7: supervisor extension absent means user passes; S ignores sup word
    request("R7", 2'd0, 1'b0, 1'b1, 1'b0, ones, '0, '0, 33);
    request("R7", 2'd1, 1'b0, 1'b1, 1'b1, ones, '0, '0, 20);
    request("R7", 2'd0, 1'b1, 1'b1, 1'b1, ones, ones, ones, 62);
    // R8: back-to-back requests
    @(negedge clk);
    curReq = "R8";
    privLevel = 2'd1; virtOn = 1'b1; stenPresent = 1'b1; supPresent = 1'b1;
    mEnable = ones; hEnable = '0; sEnable = ones; bitSelect = W'(1) << 2;
    reqStrobe = 1'b1;
    @(negedge clk);
    virtOn = 1'b0;
    @(negedge clk);
    reqStrobe = 1'b0;
    // R9: inputs change with no request
    curReq = "R9";
    request("R9", 2'd2, 1'b0, 1'b1, 1'b1, '0, '0, '0, 1);
    privLevel = 2'd3; mEnable = ones;
    repeat (4) @(negedge clk);
    // R10: reset after activity
    curReq = "R10";
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule